// File: doc/BRIEF.md
# Quad-Channel Alarm-Change Interrupt Controller

This block watches seven real-time alarm levels on each of four line channels and records every change of any alarm, whether the alarm becomes active or goes inactive. Each channel has a latched change-status register and an interrupt-enable register. Both sit on a simple byte-wide register bus with an address, a read strobe, a write strobe, write data and registered read data. The alarm detectors sit outside the block and deliver synchronous level signals.

Reading a channel's status register returns the latched changes and clears the whole register in the same cycle. A status bit only records that a change took place. Software reads the live alarm levels somewhere else. Any pending change whose enable bit is set pulls one shared active-low interrupt line low. That line stays low until every enabled pending bit has been read away or its enable has been removed.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: When an alarm input goes from 0 to 1, its status bit sets and stays set until that channel's status register is read.
- R2: When an alarm input goes from 1 to 0, its status bit also sets and stays set until that channel's status register is read.
- R3: A read of a status register returns the latched bits as they stood before the read, and it clears all of that channel's status bits at once.
- R4: A change event that lands in the same cycle as a read of its channel's status register remains latched after the clear.
- R5: The interrupt output is 0 whenever any channel has a status bit set together with its matching enable bit. Otherwise it is 1, including directly after reset.
- R6: The interrupt output returns to 1 once every enabled pending bit has been cleared by a read or its enable bit has been written to 0.
- R7: Register bits 7 down to 1 follow this order: receive analog loss of signal, receive loss of signal, transmit clock loss, transmit signal loss, transmit short, jitter buffer error, bipolar violation. Alarm input bit ch*7+k maps to register bit k+1, with k=6 for receive analog loss of signal and k=0 for bipolar violation. Bit 0 always reads 0.
- R8: Channel c (0 to 3) has its status register at address (c+1)*16+6 and its enable register at (c+1)*16+7.
- R9: Enable registers reset to 0x00. A write stores bits 7:1, and a read returns them with bit 0 at 0.
- R10: Writes to status addresses change nothing. Reads or writes to unmapped addresses change no register, and an unmapped read returns 0x00.
- R11: A status bit becomes visible on the second rising clock edge after the edge that first samples the changed alarm level. Each transition produces exactly one event.
- R12: Read data is registered. It updates on the clock edge of a read and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alarm_i | input | 28 | Alarm levels, 7 per channel, channel c in bits c*7+6 down to c*7 |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Shared active-low interrupt request |

## Verification
The assertions take the alarm inputs to be synchronous to the clock and stable across each edge. They also take the strobes to be single-cycle, with at most one read or write in a cycle. The stimulus changes every input at the falling clock edge and drives a strobe for exactly one cycle. It toggles random alarm bits, and it also holds some alarms steady long enough for events to pile up between reads. Directed cases put a change in the same cycle as a read of its own channel. They also remove an enable while a status bit is still pending, and they write to status and unmapped addresses.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int STAT_OFS = 6;
  localparam int ENAB_OFS = 7;
  localparam int CH_STRIDE = 16;

  function automatic logic [7:0] reg_addr(input int ch, input int ofs);
    return 8'((ch + 1) * CH_STRIDE + ofs);
  endfunction
endpackage

// File: rtl/alarm_rst_sync.sv
module alarm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/alarm_change_det.sv
module alarm_change_det #(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] alarm_i,
  output logic [WIDTH-1:0] evt_o
);
  logic [WIDTH-1:0] smp_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      prev_q <= '0;
    end else begin
      smp_q  <= alarm_i;
      prev_q <= smp_q;
    end
  end

  assign evt_o = smp_q ^ prev_q;

  // cycles since reset, used only to keep the checks inside valid history
  logic [1:0] warm_q, warm_d;
  always_comb warm_d = (warm_q == 2'd3) ? warm_q : warm_q + 2'd1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= warm_d;
  end

  assert_change_fires_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && alarm_i != $past(alarm_i)) |=> (evt_o != '0));

  assert_steady_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && alarm_i == $past(alarm_i)) |=> (evt_o == '0));
endmodule

// File: rtl/alarm_chan_regs.sv
module alarm_chan_regs #(
  parameter int ALARM_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ALARM_W-1:0] evt_i,
  input  logic               clr_i,
  input  logic               en_wr_i,
  input  logic [ALARM_W-1:0] en_wdata_i,
  output logic [ALARM_W-1:0] stat_o,
  output logic [ALARM_W-1:0] en_o
);
  logic [ALARM_W-1:0] stat_q, stat_d, en_q, en_d;

  always_comb begin
    stat_d = (clr_i ? '0 : stat_q) | evt_i;
    en_d   = en_wr_i ? en_wdata_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;

  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i == '0) |=> (stat_q == '0));

  assert_keep_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stat_q == $past(evt_i)));

  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_q));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int ALARM_W = 7,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH*ALARM_W-1:0] alarm_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic [ALARM_W:0]          wdata_i,
  output logic [ALARM_W:0]          rdata_o,
  output logic                      irq_n_o
);
  localparam int TOT_W = NUM_CH * ALARM_W;
  localparam int REG_W = ALARM_W + 1;

  logic                rst_q_n;
  logic [TOT_W-1:0]    evt;
  logic [ALARM_W-1:0]  stat [NUM_CH];
  logic [ALARM_W-1:0]  en   [NUM_CH];
  logic [NUM_CH-1:0]   hit_stat, hit_en;
  logic [REG_W-1:0]    rd_sel, rdata_q, rdata_d;
  logic                pend_any;

  alarm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  alarm_change_det #(.WIDTH(TOT_W)) u_det (
    .clk(clk), .rst_n(rst_q_n), .alarm_i(alarm_i), .evt_o(evt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign hit_stat[ch] = (addr_i == ADDR_W'(reg_addr(ch, STAT_OFS)));
    assign hit_en[ch]   = (addr_i == ADDR_W'(reg_addr(ch, ENAB_OFS)));

    alarm_chan_regs #(.ALARM_W(ALARM_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .evt_i     (evt[ch*ALARM_W +: ALARM_W]),
      .clr_i     (rd_i && hit_stat[ch]),
      .en_wr_i   (wr_i && hit_en[ch]),
      .en_wdata_i(wdata_i[REG_W-1:1]),
      .stat_o    (stat[ch]),
      .en_o      (en[ch])
    );
  end

  always_comb begin
    rd_sel   = '0;
    pend_any = 1'b0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (hit_stat[ch]) rd_sel = {stat[ch], 1'b0};
      if (hit_en[ch])   rd_sel = {en[ch], 1'b0};
      pend_any = pend_any | (|(stat[ch] & en[ch]));
    end
    rdata_d = rd_i ? rd_sel : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
  assign irq_n_o = ~pend_any;

  assert_bit0_zero_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    rdata_o[0] == 1'b0);

  assert_irq_release_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(irq_n_o) |-> ($past(rd_i) || $past(wr_i)));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_i |=> $stable(rdata_o));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_i && hit_stat == '0 && hit_en == '0) |=> (rdata_o == '0));
endmodule

// File: tb/sim_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module sim_alarm_irq_ctrl;
  localparam int NCH = 4;
  localparam int AW  = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [27:0]   alarm;
  logic [7:0]    addr, wdata;
  logic          rd, wr;
  logic [7:0]    rdata;
  logic          irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model state
  logic [27:0]   m_smp, m_prev;
  logic [AW-1:0] m_stat [NCH];
  logic [AW-1:0] m_en   [NCH];
  logic [7:0]    m_rd;

  always #10 clk = ~clk;

  alarm_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .alarm_i(alarm), .addr_i(addr), .rd_i(rd),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  function automatic logic [7:0] a_stat(input int ch);
    return 8'((ch + 1) * 16 + 6);
  endfunction
  function automatic logic [7:0] a_en(input int ch);
    return 8'((ch + 1) * 16 + 7);
  endfunction
  function automatic logic exp_irq_n();
    logic p = 1'b0;
    for (int ch = 0; ch < NCH; ch++) p = p | (|(m_stat[ch] & m_en[ch]));
    return ~p;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(input string tag, input logic [27:0] a, input logic r,
                     input logic w, input logic [7:0] ad, input logic [7:0] wd);
    logic [27:0] ev;
    alarm = a; rd = r; wr = w; addr = ad; wdata = wd;
    @(posedge clk);
    ev = m_smp ^ m_prev;
    if (r) m_rd = 8'h00;
    for (int ch = 0; ch < NCH; ch++) begin
      if (r && ad == a_stat(ch)) begin
        m_rd = {m_stat[ch], 1'b0};
        m_stat[ch] = ev[ch*AW +: AW];
      end else begin
        m_stat[ch] = m_stat[ch] | ev[ch*AW +: AW];
      end
      if (r && ad == a_en(ch)) m_rd = {m_en[ch], 1'b0};
      if (w && ad == a_en(ch)) m_en[ch] = wd[7:1];
    end
    m_prev = m_smp;
    m_smp  = a;
    @(negedge clk);
    chk({tag, "/R5 irq"}, {7'd0, irq_n}, {7'd0, exp_irq_n()});
    chk({tag, "/R12 rdata"}, rdata, m_rd);
  endtask

  initial begin
    logic [27:0] a;
    void'($urandom(32'h00C0FFEE));
    alarm = '0; addr = '0; wdata = '0; rd = 0; wr = 0; rst_n = 0;
    m_smp = '0; m_prev = '0; m_rd = '0;
    for (int ch = 0; ch < NCH; ch++) begin m_stat[ch] = '0; m_en[ch] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R5 reset irq", {7'd0, irq_n}, 8'h01);
    for (int ch = 0; ch < NCH; ch++) begin
      cyc("R9", '0, 1, 0, a_en(ch), 0);
      chk("R9 enable reset", rdata, 8'h00);
    end

    // enable channel 0, read back
    cyc("R9", '0, 0, 1, a_en(0), 8'hFF);
    cyc("R9", '0, 1, 0, a_en(0), 0);
    chk("R9 enable readback", rdata, 8'hFE);

    // rising edge on ch0 receive analog loss of signal (alarm bit 6)
    a = 28'h40;
    cyc("R11", a, 0, 0, 0, 0);
    chk("R11 not yet visible", {7'd0, irq_n}, 8'h01);
    cyc("R11", a, 0, 0, 0, 0);
    chk("R11 visible second edge", {7'd0, irq_n}, 8'h00);
    cyc("R1", a, 0, 0, 0, 0);
    cyc("R1", a, 1, 0, a_stat(0), 0);
    chk("R1 R7 rise latched at bit7", rdata, 8'h80);
    chk("R6 irq released by read", {7'd0, irq_n}, 8'h01);
    cyc("R3", a, 1, 0, a_stat(0), 0);
    chk("R3 cleared", rdata, 8'h00);

    // falling edge
    a = '0;
    repeat (3) cyc("R2", a, 0, 0, 0, 0);
    cyc("R2", a, 1, 0, a_stat(0), 0);
    chk("R2 fall latched", rdata, 8'h80);

    // event concurrent with read on ch1 bipolar violation (alarm bit 7)
    a = 28'h80;
    cyc("R4", a, 0, 0, 0, 0);
    cyc("R4", a, 1, 0, a_stat(1), 0);
    chk("R4 pre-clear value", rdata, 8'h00);
    cyc("R4", a, 1, 0, a_stat(1), 0);
    chk("R4 event kept", rdata, 8'h02);

    // status write ignored, unmapped access
    a = a | 28'h1 << 14;
    repeat (2) cyc("R10", a, 0, 0, 0, 0);
    cyc("R10", a, 0, 1, a_stat(2), 8'h00);
    cyc("R10", a, 0, 1, 8'h57, 8'hFF);
    cyc("R10", a, 1, 0, 8'h55, 0);
    chk("R10 unmapped read", rdata, 8'h00);
    cyc("R10", a, 1, 0, a_stat(2), 0);
    chk("R10 R8 status write ignored", rdata, 8'h02);
    cyc("R10", a, 1, 0, a_en(3), 0);
    chk("R10 unmapped write no effect", rdata, 8'h00);

    // enable removal releases irq, ch3 transmit short (alarm bit 21+2)
    a = a ^ (28'h1 << 23);
    cyc("R6", a, 0, 1, a_en(3), 8'h08);
    repeat (2) cyc("R6", a, 0, 0, 0, 0);
    chk("R6 enabled pending irq", {7'd0, irq_n}, 8'h00);
    cyc("R6", a, 0, 1, a_en(3), 8'h00);
    chk("R6 irq released by enable removal", {7'd0, irq_n}, 8'h01);
    cyc("R8", a, 1, 0, a_stat(3), 0);
    chk("R8 ch3 status", rdata, 8'h08);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ad;
      int ch = $urandom_range(0, NCH - 1);
      int k  = $urandom_range(0, 9);
      if ($urandom_range(0, 5) == 0) a = a ^ (28'h1 << $urandom_range(0, 27));
      ad = (k < 4) ? a_stat(ch) : (k < 8) ? a_en(ch) : 8'($urandom);
      case ($urandom_range(0, 3))
        0:       cyc("R3 rand", a, 1, 0, ad, 0);
        1:       cyc("R9 rand", a, 0, 1, ad, 8'($urandom));
        default: cyc("R1 R2 rand", a, 0, 0, ad, 0);
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule